// File: doc/BRIEF.md
# Sub-Register Partitioned General Register File

This block holds eight 32-bit general registers behind one write port and two read ports. Each access names a register index and an access size. A full-width access covers the whole register. A word access covers bits 15:0. The two byte sizes cover bits 7:0 and bits 15:8. The first four registers can be split into bytes. The other four accept only word and full-width accesses.

A narrow write merges into the stored register, and every bit outside the named field keeps its value. A narrow read returns the named field in the low bits of the read bus, with zeros above it. A byte access that names a register which cannot be split is flagged as illegal. An illegal write stores nothing, and an illegal read returns zero. The read ports are combinational and have no bypass, so a read in the same cycle as a write to that register returns the value held before the write.

Top module: `subreg_file`

## Requirements
- R1: After reset every register reads as zero at full width on both read ports.
- R2: A full-width write (size code 3) to any index replaces all 32 bits, and a full-width read returns all 32 bits. Registers that are not addressed by a write keep their values.
- R3: A word write (size code 2) changes only bits 15:0, and a word read returns bits 15:0 with bits 31:16 driven to zero.
- R4: A low-byte write (size code 0) changes only bits 7:0 of indices 0 to 3, and a low-byte read returns bits 7:0 with bits 31:8 driven to zero.
- R5: A high-byte write (size code 1) changes only bits 15:8 of indices 0 to 3, and a high-byte read returns bits 15:8 on read bits 7:0 with bits 31:8 driven to zero.
- R6: A byte-size access (code 0 or 1) to index 4 to 7 raises the illegal flag of its port. An illegal write leaves the register file unchanged, and an illegal read returns zero. wr_illegal is raised only while wr_en is high.
- R7: A read in the same cycle as a write to the same register returns the value from before the write.
- R8: The two read ports select and size their data independently of each other.
- R9: While wr_en is low, no register changes and wr_illegal stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Register index written |
| wr_size | input | 2 | Write size: 0 low byte, 1 high byte, 2 word, 3 full |
| wr_data | input | 32 | Write data; the narrow field is taken from its low bits |
| wr_illegal | output | 1 | Write named a byte of a register that cannot be split |
| rd0_idx | input | 3 | Read port 0 register index |
| rd0_size | input | 2 | Read port 0 size code |
| rd0_data | output | 32 | Read port 0 zero-extended data |
| rd0_illegal | output | 1 | Read port 0 illegal byte access |
| rd1_idx | input | 3 | Read port 1 register index |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_data | output | 32 | Read port 1 zero-extended data |
| rd1_illegal | output | 1 | Read port 1 illegal byte access |

## Verification
The assertions check on every cycle that the bits outside the written field keep their values, that a register which is not addressed does not change, that an illegal write leaves the file unchanged, that full-width writes load the data, and that narrow reads zero-fill the upper bits. Only the bench scenarios can show the reset contents, the exact field placement for the high byte, the old-value result of a read that collides with a write, and the values carried across a series of mixed-size writes.

// File: rtl/subreg_pkg.sv
package subreg_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        ACC_BLO   = 2'd0,
        ACC_BHI   = 2'd1,
        ACC_WORD  = 2'd2,
        ACC_DWORD = 2'd3
    } acc_size_e;

    function automatic logic is_byte_size(acc_size_e s);
        return (s == ACC_BLO) || (s == ACC_BHI);
    endfunction

endpackage

// File: rtl/subreg_access_chk.sv
module subreg_access_chk
    import subreg_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int NSPLIT = 4,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic [IDX_W-1:0] idx,
    input  acc_size_e        size,
    output logic             illegal
);

    always_comb begin
        illegal = is_byte_size(size) && (int'(idx) >= NSPLIT);
    end

endmodule

// File: rtl/subreg_merge.sv
module subreg_merge
    import subreg_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] wdata,
    input  acc_size_e       size,
    output logic [XLEN-1:0] merged
);

    always_comb begin
        merged = old_val;
        unique case (size)
            ACC_BLO:   merged[BYTE_W-1:0]      = wdata[BYTE_W-1:0];
            ACC_BHI:   merged[WORD_W-1:BYTE_W] = wdata[BYTE_W-1:0];
            ACC_WORD:  merged[WORD_W-1:0]      = wdata[WORD_W-1:0];
            ACC_DWORD: merged                  = wdata;
            default:   merged                  = old_val;
        endcase
    end

endmodule

// File: rtl/subreg_read_port.sv
module subreg_read_port
    import subreg_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int XLEN   = 32,
    parameter int NSPLIT = 4,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NREG-1:0][XLEN-1:0] regs,
    input  logic [IDX_W-1:0]          idx,
    input  acc_size_e                 size,
    output logic [XLEN-1:0]           data,
    output logic                      illegal
);

    logic [XLEN-1:0] sel;

    subreg_access_chk #(.NREG(NREG), .NSPLIT(NSPLIT)) u_chk (
        .idx     (idx),
        .size    (size),
        .illegal (illegal)
    );

    always_comb begin
        sel  = regs[idx];
        data = '0;
        if (!illegal) begin
            unique case (size)
                ACC_BLO:   data[BYTE_W-1:0] = sel[BYTE_W-1:0];
                ACC_BHI:   data[BYTE_W-1:0] = sel[WORD_W-1:BYTE_W];
                ACC_WORD:  data[WORD_W-1:0] = sel[WORD_W-1:0];
                ACC_DWORD: data             = sel;
                default:   data             = '0;
            endcase
        end
    end

    p_word_zext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (size == ACC_WORD) |-> (data[XLEN-1:WORD_W] == '0));

    p_byte_zext_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_byte_size(size) |-> (data[XLEN-1:BYTE_W] == '0));

    p_illegal_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (data == '0));

endmodule

// File: rtl/subreg_file.sv
module subreg_file
    import subreg_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int XLEN   = 32,
    parameter int NSPLIT = 4,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0]       wr_size,
    input  logic [XLEN-1:0]  wr_data,
    output logic             wr_illegal,
    input  logic [IDX_W-1:0] rd0_idx,
    input  logic [1:0]       rd0_size,
    output logic [XLEN-1:0]  rd0_data,
    output logic             rd0_illegal,
    input  logic [IDX_W-1:0] rd1_idx,
    input  logic [1:0]       rd1_size,
    output logic [XLEN-1:0]  rd1_data,
    output logic             rd1_illegal
);

    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] regs;
    } state_t;

    state_t          state_d, state_q;
    logic            wr_bad;
    logic [XLEN-1:0] wr_merged;
    acc_size_e       wr_size_e;

    assign wr_size_e = acc_size_e'(wr_size);

    subreg_access_chk #(.NREG(NREG), .NSPLIT(NSPLIT)) u_wr_chk (
        .idx     (wr_idx),
        .size    (wr_size_e),
        .illegal (wr_bad)
    );

    subreg_merge #(.XLEN(XLEN)) u_merge (
        .old_val (state_q.regs[wr_idx]),
        .wdata   (wr_data),
        .size    (wr_size_e),
        .merged  (wr_merged)
    );

    always_comb begin
        state_d    = state_q;
        wr_illegal = wr_en && wr_bad;
        if (wr_en && !wr_bad) begin
            state_d.regs[wr_idx] = wr_merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    subreg_read_port #(.NREG(NREG), .XLEN(XLEN), .NSPLIT(NSPLIT)) u_rd0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .regs    (state_q.regs),
        .idx     (rd0_idx),
        .size    (acc_size_e'(rd0_size)),
        .data    (rd0_data),
        .illegal (rd0_illegal)
    );

    subreg_read_port #(.NREG(NREG), .XLEN(XLEN), .NSPLIT(NSPLIT)) u_rd1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .regs    (state_q.regs),
        .idx     (rd1_idx),
        .size    (acc_size_e'(rd1_size)),
        .data    (rd1_data),
        .illegal (rd1_illegal)
    );

    // Registers not addressed by a legal write hold their value (R2, R9)
    for (genvar g = 0; g < NREG; g++) begin : g_hold
        p_unaddressed_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && !wr_illegal && (int'(wr_idx) == g)) |=> $stable(state_q.regs[g]));
    end

    p_illegal_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_illegal |=> (state_q == $past(state_q)));

    p_idle_no_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> !wr_illegal);

    p_dword_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size_e == ACC_DWORD) |=> (state_q.regs[$past(wr_idx)] == $past(wr_data)));

    p_word_keep_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size_e == ACC_WORD) |=>
        (state_q.regs[$past(wr_idx)][XLEN-1:WORD_W] == $past(state_q.regs[wr_idx][XLEN-1:WORD_W])));

    p_blo_keep_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_illegal && wr_size_e == ACC_BLO) |=>
        (state_q.regs[$past(wr_idx)][XLEN-1:BYTE_W] == $past(state_q.regs[wr_idx][XLEN-1:BYTE_W])));

    p_bhi_keep_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_illegal && wr_size_e == ACC_BHI) |=>
        ((state_q.regs[$past(wr_idx)][BYTE_W-1:0] == $past(state_q.regs[wr_idx][BYTE_W-1:0])) &&
         (state_q.regs[$past(wr_idx)][XLEN-1:WORD_W] == $past(state_q.regs[wr_idx][XLEN-1:WORD_W]))));

endmodule

// File: tb/subreg_file_bench.sv
module subreg_file_bench;
    import subreg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [1:0]  wr_size = '0;
    logic [31:0] wr_data = '0;
    logic        wr_illegal;
    logic [2:0]  rd0_idx = '0;
    logic [1:0]  rd0_size = 2'd3;
    logic [31:0] rd0_data;
    logic        rd0_illegal;
    logic [2:0]  rd1_idx = '0;
    logic [1:0]  rd1_size = 2'd3;
    logic [31:0] rd1_data;
    logic        rd1_illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    subreg_file u_subreg_file (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data),
        .wr_illegal(wr_illegal),
        .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_data(rd0_data), .rd0_illegal(rd0_illegal),
        .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_data(rd1_data), .rd1_illegal(rd1_illegal)
    );

    typedef struct packed {
        logic        we;
        logic [2:0]  widx;
        logic [1:0]  wsz;
        logic [31:0] wdat;
        logic [2:0]  r0i;
        logic [1:0]  r0s;
        logic [31:0] r0e;
        logic [2:0]  r1i;
        logic [1:0]  r1s;
        logic [31:0] r1e;
        logic        wille;
        logic        r1ille;
    } vec_t;

    // Reads show the state before the row's write; writes land at the next edge.
    localparam int NVEC = 11;
    localparam vec_t VEC [NVEC] = '{
        // R2 R7: full write to r0, same-cycle read sees the old zero
        '{1'b1, 3'd0, 2'd3, 32'h11223344, 3'd0, 2'd3, 32'h0,        3'd1, 2'd3, 32'h0,    1'b0, 1'b0},
        // R4 R5 R8: low-byte write; ports read full and high byte
        '{1'b1, 3'd0, 2'd0, 32'hFFFFFFAA, 3'd0, 2'd3, 32'h11223344, 3'd0, 2'd1, 32'h33,   1'b0, 1'b0},
        // R5 R3: high-byte write; read low byte and word
        '{1'b1, 3'd0, 2'd1, 32'h000000BB, 3'd0, 2'd0, 32'hAA,       3'd0, 2'd2, 32'h33AA, 1'b0, 1'b0},
        // R3: word write keeps 31:16
        '{1'b1, 3'd0, 2'd2, 32'h5555CCDD, 3'd0, 2'd3, 32'h1122BBAA, 3'd0, 2'd1, 32'hBB,   1'b0, 1'b0},
        // R2: full write to r5
        '{1'b1, 3'd5, 2'd3, 32'hDEADBEEF, 3'd0, 2'd3, 32'h1122CCDD, 3'd0, 2'd2, 32'hCCDD, 1'b0, 1'b0},
        // R6: byte write to r5 is illegal
        '{1'b1, 3'd5, 2'd0, 32'h00000012, 3'd5, 2'd3, 32'hDEADBEEF, 3'd5, 2'd2, 32'hBEEF, 1'b1, 1'b0},
        // R6: r5 unchanged; high-byte read of r5 flagged and zero
        '{1'b1, 3'd5, 2'd2, 32'h00007777, 3'd5, 2'd3, 32'hDEADBEEF, 3'd5, 2'd1, 32'h0,    1'b0, 1'b1},
        // R5: high-byte write to r3
        '{1'b1, 3'd3, 2'd1, 32'h0000009C, 3'd5, 2'd3, 32'hDEAD7777, 3'd3, 2'd3, 32'h0,    1'b0, 1'b0},
        // R6: high-byte write to r7 illegal
        '{1'b1, 3'd7, 2'd1, 32'h00000001, 3'd3, 2'd3, 32'h00009C00, 3'd3, 2'd0, 32'h0,    1'b1, 1'b0},
        // R9: no write, byte size on r6 raises no flag
        '{1'b0, 3'd6, 2'd0, 32'h000000FF, 3'd7, 2'd3, 32'h0,        3'd3, 2'd1, 32'h9C,   1'b0, 1'b0},
        // R9: r6 untouched
        '{1'b0, 3'd1, 2'd3, 32'hFFFFFFFF, 3'd6, 2'd3, 32'h0,        3'd7, 2'd2, 32'h0,    1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic read_all_zero(input string tag);
        wr_en = 1'b0;
        for (int i = 0; i < 8; i += 2) begin
            @(negedge clk);
            rd0_idx = 3'(i); rd0_size = 2'd3;
            rd1_idx = 3'(i + 1); rd1_size = 2'd3;
            #5;
            check(tag, rd0_data, 32'h0);
            check(tag, rd1_data, 32'h0);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        read_all_zero("R1 reset");

        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            wr_en = VEC[v].we; wr_idx = VEC[v].widx; wr_size = VEC[v].wsz; wr_data = VEC[v].wdat;
            rd0_idx = VEC[v].r0i; rd0_size = VEC[v].r0s;
            rd1_idx = VEC[v].r1i; rd1_size = VEC[v].r1s;
            #5;
            check($sformatf("table row %0d rd0", v), rd0_data, VEC[v].r0e);
            check($sformatf("table row %0d rd1", v), rd1_data, VEC[v].r1e);
            check($sformatf("table row %0d wr_illegal", v), {31'b0, wr_illegal}, {31'b0, VEC[v].wille});
            check($sformatf("table row %0d rd1_illegal", v), {31'b0, rd1_illegal}, {31'b0, VEC[v].r1ille});
        end

        // R6: byte read on r4 flagged; low byte of r0 legal
        @(negedge clk);
        wr_en = 1'b0;
        rd0_idx = 3'd4; rd0_size = 2'd0;
        rd1_idx = 3'd0; rd1_size = 2'd0;
        #5;
        check("R6 rd0_illegal on r4", {31'b0, rd0_illegal}, 32'h1);
        check("R4 rd1 low byte r0", rd1_data, 32'hDD);
        check("R4 rd1_illegal on r0", {31'b0, rd1_illegal}, 32'h0);

        // R3: word write to a non-splittable register keeps upper half
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd5; wr_size = 2'd2; wr_data = 32'hFFFF0001;
        @(negedge clk);
        wr_en = 1'b0;
        rd0_idx = 3'd5; rd0_size = 2'd3;
        #5;
        check("R3 word write r5", rd0_data, 32'hDEAD0001);

        // R1: reset again clears contents
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_all_zero("R1 second reset");

        finish_run();
    end

endmodule